// File: doc/BRIEF.md
# Power-Managed ADC Frame Sequencer

This block is the host side of a link to a 16-channel, 12-bit serial converter that is left in one of its automatic low-power modes. Such a converter drops into shutdown or standby when chip select rises after each conversion frame. It starts waking only on the next chip-select fall and needs about a microsecond before it can convert properly. The sequencer takes conversion requests (a channel number plus a choice of auto-shutdown or auto-standby) through a valid/ready handshake and holds them in a small queue. It turns each request into two serial frames. The first is a wake-up frame with every DIN bit at zero, so the converter's control register is not rewritten. The second is a real frame that writes the control word and returns the result.

A state machine with four states runs the block. **IDLE** keeps chip select high. It leaves for **DUMMY** (transition *launch*, which pops the queue) once a request is waiting and chip select has been high for the minimum time. **DUMMY** runs the wake-up frame and goes to **GAP** on frame completion (transition *wake_done*). **GAP** holds chip select high until two conditions hold: the minimum high time has passed, and the wake-up window counted from the dummy frame's chip-select fall has run out. It then moves to **REAL** (transition *fire*). **REAL** runs the frame that carries the control word. On completion (transition *retire*) it returns to IDLE and presents the captured channel tag and result with a one-cycle valid pulse. Only every other frame yields a result, so the usable rate is half the frame rate.

The serial clock idles high and is divided down from the system clock by a parameter. Each frame opens with one high half-period after chip select falls, then runs sixteen low/high SCLK periods. The host changes DIN when SCLK falls and samples DOUT when SCLK rises.

Top module: `adc_frame_seq`

## Requirements
- R1: While a frame runs, adc_cs_n stays low and adc_sclk gives exactly 16 low pulses. adc_sclk is high whenever adc_cs_n is high.
- R2: A real frame shifts a 16-bit word out MSB first on adc_din. Bit 15 is the write enable (1), bit 14 is 0, bits 13:10 carry the requested channel, and bits 9:8 are the power-mode pair: 01 when req_shutdown=1 (auto shutdown) and 00 when req_shutdown=0 (auto standby). Bits 7:0 are 0.
- R3: Each accepted request first produces a wake-up frame whose 16 adc_din bits are all 0, so the write enable is off.
- R4: The chip-select fall of a real frame comes at least WAKE_CYCLES system clocks after the chip-select fall of the wake-up frame before it. When the wake-up frame is shorter than that, idle time is added.
- R5: Between two frames, adc_cs_n stays high for at least CS_HIGH_MIN system clocks.
- R6: adc_dout is sampled on each adc_sclk rising edge, MSB first. After a real frame, result_tag holds word bits 15:12 and result_data holds bits 11:0. result_valid is high for exactly one cycle, the cycle in which adc_cs_n returns high.
- R7: A wake-up frame never raises result_valid. Each accepted request gives exactly one result.
- R8: A request is accepted on a clock where req_valid and req_ready are both high. Up to QUEUE_DEPTH waiting requests are held and served in the order accepted. req_ready is low while the queue is full, and no request is dropped.
- R9: During reset, adc_cs_n=1, adc_sclk=1, adc_din=0, result_valid=0 and req_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Conversion request offered |
| req_ready | output | 1 | Queue can take a request |
| req_chan | input | 4 | Channel to convert |
| req_shutdown | input | 1 | 1 selects auto shutdown, 0 selects auto standby |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_din | output | 1 | Serial data to the converter |
| adc_dout | input | 1 | Serial data from the converter |
| result_valid | output | 1 | One-cycle pulse marking a valid result |
| result_tag | output | 4 | Channel tag from the returned word |
| result_data | output | 12 | Conversion result from the returned word |

## Verification
The bench builds the block with SCLK_DIV=2, WAKE_CYCLES=100, CS_HIGH_MIN=3 and QUEUE_DEPTH=4. With these values the wake-up frame holds chip select low for 67 clocks, which is shorter than the wake window. The GAP state therefore has to stretch the idle time, and the bench can measure that path. A burst of back-to-back requests against a queue of four fills the queue, so req_ready drops and the bench can observe in-order service with no request lost. A behavioural converter model in the bench returns a tag and a value that depend on the frame, so both the capture order and the tag/result split are compared.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    localparam int FRAME_BITS = 16;
    localparam int CHAN_W     = 4;
    localparam int RES_W      = 12;
    localparam int TAG_W      = FRAME_BITS - RES_W;
    localparam int PAD_W      = FRAME_BITS - CHAN_W - 4;

    typedef enum logic [1:0] {
        S_IDLE,
        S_DUMMY,
        S_GAP,
        S_REAL
    } seq_state_t;

    typedef struct packed {
        logic              shutdown;
        logic [CHAN_W-1:0] chan;
    } conv_req_t;

    // write enable, sequencer off, channel, power-mode pair, zero padding
    function automatic logic [FRAME_BITS-1:0] make_ctrl(conv_req_t r);
        return {1'b1, 1'b0, r.chan, 1'b0, r.shutdown, {PAD_W{1'b0}}};
    endfunction
endpackage

// File: rtl/adc_req_fifo.sv
module adc_req_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    input  logic         out_pop,
    output logic         out_avail,
    output logic [W-1:0] out_data
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;
    logic          push, pop;

    assign in_ready  = (cnt_q != CW'(DEPTH));
    assign out_avail = (cnt_q != '0);
    assign push      = in_valid && in_ready;
    assign pop       = out_pop && out_avail;
    assign out_data  = mem[rd_q];

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= in_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
    parameter int CLK_DIV = 1,
    parameter int BITS    = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [BITS-1:0] tx_word,
    input  logic            dout,
    output logic            busy,
    output logic            done,
    output logic            sclk,
    output logic            din,
    output logic [BITS-1:0] rx_word
);
    localparam int HALVES = 2 * BITS + 1;
    localparam int HW     = $clog2(HALVES + 1);
    localparam int DW     = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

    logic            busy_q, done_q;
    logic [DW-1:0]   div_q;
    logic [HW-1:0]   half_q;
    logic [BITS-1:0] tx_q, rx_q;
    logic            half_end;

    assign half_end = busy_q && (div_q == DW'(CLK_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            div_q  <= '0;
            half_q <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q) begin
                if (start) begin
                    busy_q <= 1'b1;
                    div_q  <= '0;
                    half_q <= '0;
                    tx_q   <= tx_word;
                end
            end else if (half_end) begin
                div_q  <= '0;
                half_q <= half_q + 1'b1;
                if (half_q[0])
                    rx_q <= {rx_q[BITS-2:0], dout};
                else if (half_q != '0)
                    tx_q <= tx_q << 1;
                if (half_q == HW'(HALVES - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign sclk    = !(busy_q && half_q[0]);
    assign din     = busy_q && tx_q[BITS-1];
    assign rx_word = rx_q;

    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/adc_frame_seq.sv
module adc_frame_seq
    import adc_seq_pkg::*;
#(
    parameter int SCLK_DIV    = 1,
    parameter int WAKE_CYCLES = 40,
    parameter int CS_HIGH_MIN = 2,
    parameter int QUEUE_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CHAN_W-1:0] req_chan,
    input  logic              req_shutdown,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic              adc_din,
    input  logic              adc_dout,
    output logic              result_valid,
    output logic [TAG_W-1:0]  result_tag,
    output logic [RES_W-1:0]  result_data
);
    localparam int REQ_W    = $bits(conv_req_t);
    localparam int WAKE_LIM = WAKE_CYCLES - 1;
    localparam int WKW      = $clog2(WAKE_CYCLES + 1);
    localparam int CSH_LIM  = CS_HIGH_MIN - 1;
    localparam int CHW      = $clog2(CS_HIGH_MIN + 1);

    seq_state_t state_q, state_d;
    conv_req_t  cur_q;
    logic [REQ_W-1:0]      q_out;
    logic                  q_avail, pop;
    logic                  start_frame, cs_low;
    logic [FRAME_BITS-1:0] tx_word, rx_word;
    logic                  busy, frame_done;
    logic [WKW-1:0]        wake_q;
    logic [CHW-1:0]        csh_q;
    logic                  wake_ok, csh_ok;
    logic                  rv_q;
    logic [TAG_W-1:0]      tag_q;
    logic [RES_W-1:0]      data_q;

    adc_req_fifo #(.DEPTH(QUEUE_DEPTH), .W(REQ_W)) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .in_ready (req_ready),
        .in_data  ({req_shutdown, req_chan}),
        .out_pop  (pop),
        .out_avail(q_avail),
        .out_data (q_out)
    );

    adc_frame_shifter #(.CLK_DIV(SCLK_DIV), .BITS(FRAME_BITS)) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_frame),
        .tx_word(tx_word),
        .dout   (adc_dout),
        .busy   (busy),
        .done   (frame_done),
        .sclk   (adc_sclk),
        .din    (adc_din),
        .rx_word(rx_word)
    );

    assign wake_ok = (wake_q == WKW'(WAKE_LIM));
    assign csh_ok  = (csh_q == CHW'(CSH_LIM));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        start_frame = 1'b0;
        pop         = 1'b0;
        tx_word     = '0;
        cs_low      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (q_avail && csh_ok) begin      // launch
                    pop         = 1'b1;
                    start_frame = 1'b1;
                    state_d     = S_DUMMY;
                end
            end
            S_DUMMY: begin
                cs_low = 1'b1;
                if (frame_done) state_d = S_GAP;  // wake_done
            end
            S_GAP: begin
                if (csh_ok && wake_ok) begin      // fire
                    start_frame = 1'b1;
                    tx_word     = make_ctrl(cur_q);
                    state_d     = S_REAL;
                end
            end
            S_REAL: begin
                cs_low = 1'b1;
                if (frame_done) state_d = S_IDLE; // retire
            end
            default: state_d = S_IDLE;
        endcase
    end

    assign adc_cs_n = !cs_low;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            wake_q <= '0;
            csh_q  <= CHW'(CSH_LIM);
            rv_q   <= 1'b0;
            tag_q  <= '0;
            data_q <= '0;
        end else begin
            if (pop) cur_q <= conv_req_t'(q_out);

            if (state_q == S_DUMMY || state_q == S_GAP) begin
                if (!wake_ok) wake_q <= wake_q + 1'b1;
            end else begin
                wake_q <= '0;
            end

            if (cs_low)       csh_q <= '0;
            else if (!csh_ok) csh_q <= csh_q + 1'b1;

            rv_q <= 1'b0;
            if (state_q == S_REAL && frame_done) begin
                rv_q   <= 1'b1;
                tag_q  <= rx_word[FRAME_BITS-1:RES_W];
                data_q <= rx_word[RES_W-1:0];
            end
        end
    end

    assign result_valid = rv_q;
    assign result_tag   = tag_q;
    assign result_data  = data_q;

    assert_cs_covers_frame_R1: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !adc_cs_n);
    assert_dummy_write_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DUMMY) |-> !adc_din);
    assert_wake_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_REAL && $past(state_q) == S_GAP) |-> ($past(wake_q) == WKW'(WAKE_LIM)));
    assert_cs_high_min_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> ($past(csh_q) == CHW'(CSH_LIM)));
    assert_result_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);
    assert_valid_after_real_R7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> ($past(state_q) == S_REAL));
endmodule

// File: tb/adc_frame_seq_tb_top.sv
`timescale 1ns/1ps
module adc_frame_seq_tb_top;
    localparam int DIV   = 2;
    localparam int WAKE  = 100;
    localparam int CSH   = 3;
    localparam int DEPTH = 4;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_chan = '0;
    logic        req_shutdown = 1'b0;
    logic        adc_cs_n, adc_sclk, adc_din;
    logic        adc_dout = 1'b0;
    logic        result_valid;
    logic [3:0]  result_tag;
    logic [11:0] result_data;

    adc_frame_seq #(
        .SCLK_DIV(DIV), .WAKE_CYCLES(WAKE), .CS_HIGH_MIN(CSH), .QUEUE_DEPTH(DEPTH)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_chan(req_chan), .req_shutdown(req_shutdown),
        .adc_cs_n(adc_cs_n), .adc_sclk(adc_sclk), .adc_din(adc_din),
        .adc_dout(adc_dout),
        .result_valid(result_valid), .result_tag(result_tag), .result_data(result_data)
    );

    always #10 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done_flag = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc == WATCHDOG) begin
            chk(0, "watchdog", cyc, 0);
            finish_run();
        end
    end

    // behavioural converter model and reference
    logic [4:0]  reqs[$];
    logic [15:0] exp_res[$];
    logic [15:0] adc_out = '0;
    logic [15:0] din_cap = '0;
    logic [3:0]  adc_addr = '0;
    int rise_n = 0;
    int fidx = 0;
    int last_rise_cyc = -1000;
    int dummy_fall_cyc = 0;
    int exp_valid_cyc = -1;
    int res_seen = 0;

    function automatic logic [11:0] sample_val(int f);
        return 12'((f * 291 + 17) & 4095);
    endfunction

    always @(negedge adc_cs_n) if (rst_n === 1'b1) begin
        chk(cyc - last_rise_cyc >= CSH, "R5 cs high time", cyc - last_rise_cyc, CSH);
        if (fidx % 2 == 1)
            chk(cyc - dummy_fall_cyc >= WAKE, "R4 wake window", cyc - dummy_fall_cyc, WAKE);
        else
            dummy_fall_cyc = cyc;
        rise_n  = 0;
        din_cap = '0;
        adc_out = {adc_addr, sample_val(fidx)};
        if (fidx % 2 == 1) exp_res.push_back(adc_out);
        adc_dout = adc_out[15];
    end

    always @(posedge adc_sclk) if (rst_n === 1'b1 && adc_cs_n === 1'b0) begin
        din_cap  = {din_cap[14:0], adc_din};
        rise_n   = rise_n + 1;
        adc_out  = adc_out << 1;
        adc_dout = adc_out[15];
    end

    always @(posedge adc_cs_n) if (rst_n === 1'b1) begin
        logic [4:0]  r;
        logic [15:0] want;
        chk(rise_n == 16, "R1 sclk pulses per frame", rise_n, 16);
        if (fidx % 2 == 0) begin
            chk(din_cap == 16'h0000, "R3 wake frame din", din_cap, 0);
        end else begin
            r    = reqs[fidx / 2];
            want = {1'b1, 1'b0, r[3:0], 1'b0, r[4], 8'h00};
            chk(din_cap == want, "R2 control word", din_cap, want);
            if (din_cap[15]) adc_addr = din_cap[13:10];
            exp_valid_cyc = cyc;
        end
        last_rise_cyc = cyc;
        fidx = fidx + 1;
    end

    // compared on every clock
    always @(negedge clk) if (rst_n === 1'b1) begin
        chk(result_valid == (cyc == exp_valid_cyc), "R6/R7 result_valid timing",
            result_valid, cyc == exp_valid_cyc);
        chk(!(adc_cs_n && !adc_sclk), "R1 sclk idle high", adc_sclk, 1);
        if (result_valid) begin
            if (exp_res.size() == 0) begin
                chk(0, "R7 unexpected result", {result_tag, result_data}, 0);
            end else begin
                logic [15:0] e;
                e = exp_res.pop_front();
                chk({result_tag, result_data} == e, "R6 tag/result", {result_tag, result_data}, e);
            end
            res_seen++;
        end
    end

    bit saw_full = 0;

    task automatic push_req(input logic [3:0] ch, input logic sd);
        req_chan     = ch;
        req_shutdown = sd;
        req_valid    = 1'b1;
        while (!req_ready) begin
            saw_full = 1;
            @(negedge clk);
        end
        reqs.push_back({sd, ch});
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_results(input int n);
        while (res_seen < n && cyc < WATCHDOG - 10) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(adc_cs_n === 1'b1, "R9 cs_n in reset", adc_cs_n, 1);
        chk(adc_sclk === 1'b1, "R9 sclk in reset", adc_sclk, 1);
        chk(adc_din === 1'b0, "R9 din in reset", adc_din, 0);
        chk(result_valid === 1'b0, "R9 result_valid in reset", result_valid, 0);
        chk(req_ready === 1'b1, "R9 req_ready in reset", req_ready, 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        push_req(4'd5, 1'b1);
        wait_results(1);
        push_req(4'd10, 1'b0);
        wait_results(2);

        // burst: R8 queueing and back-pressure
        push_req(4'd15, 1'b1);
        push_req(4'd0, 1'b0);
        push_req(4'd3, 1'b1);
        push_req(4'd7, 1'b0);
        push_req(4'd9, 1'b1);
        push_req(4'd12, 1'b0);
        chk(saw_full, "R8 req_ready low when full", saw_full, 1);
        wait_results(reqs.size());
        chk(res_seen == reqs.size(), "R7 one result per request", res_seen, reqs.size());

        repeat (200) @(negedge clk);
        chk(fidx == 2 * reqs.size(), "R3 two frames per request", fidx, 2 * reqs.size());
        chk(exp_res.size() == 0, "R8 all results delivered", exp_res.size(), 0);
        chk(adc_cs_n === 1'b1, "R1 idle after queue drained", adc_cs_n, 1);
        finish_run();
    end
endmodule